// File: doc/BRIEF.md
# Interrupt Flag and Pin Controller

This block merges three event sources (a watchdog timeout, an alarm match and a power-fail warning) onto one interrupt pin. Each event sets its own sticky bit in a flag register. A host reads the flag register to learn the cause. The read strobe clears every flag at once and ends any active assertion on the pin. A small control register holds one enable bit per source and two mode bits. The first mode bit selects the pin polarity together with its drive style. The second selects a level output or a pulse of fixed width.

The pin stays quiet while the supply monitor reports that the device is running from backup power. It also stays quiet until the power-up recall sequence has finished. Flags still record events in both cases. The pulse width is a parameter counted in clock cycles. The pad is modelled as a data/enable pair: the pad is driven when the enable is 1 and is high impedance when it is 0.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After a synchronous reset the flag register reads 0, the control register is 0, and the pin is released (`pin_oe`=0, `pin_drv`=0).
- R2: An event on `evt_in` bit i (bit 0 watchdog, bit 1 alarm, bit 2 power fail) sets flag bit i in the cycle after the event edge. The flag stays set until a read.
- R3: `flags_rd` clears all flags one cycle after the strobe edge. A flag whose event arrives on the same edge as the read stays set.
- R4: Control bits [2:0] are the per-source enables, in the same order as the flags. The pin asserts only for a flag whose enable is 1. A source whose enable is 0 only updates its flag.
- R5: With control bit 4 (pulse mode) at 0, the pin becomes active two edges after an enabled event. It stays active until the edge that follows the read strobe's edge.
- R6: With control bit 4 at 1, the pin is active for exactly `PULSE_CYC` cycles, starting two edges after the enabled condition rises. Further events during the pulse, or a flag that is left set afterwards, do not start it again.
- R7: A read strobe during a pulse ends it: the pin is inactive from the edge after the strobe's edge.
- R8: With control bit 3 at 1, the pin is push-pull active high (`pin_oe`=1, `pin_drv` equal to the active state). With control bit 3 at 0, it is open drain active low: `pin_drv`=0, and `pin_oe` is 1 only while active.
- R9: While `supply_ok` or `recall_done` is 0, the pin is inactive one edge later. Flags are still set by events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | N_SRC | One-cycle source events: [0] watchdog, [1] alarm, [2] power fail |
| flags_rd | input | 1 | Flag register read strobe (clears the flags) |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | N_SRC+2 | Control data: enables [N_SRC-1:0], polarity [N_SRC], pulse mode [N_SRC+1] |
| supply_ok | input | 1 | Main supply valid (0 = running on backup) |
| recall_done | input | 1 | Power-up recall sequence finished |
| flags_q | output | N_SRC | Current sticky flags |
| pin_drv | output | 1 | Pad data value |
| pin_oe | output | 1 | Pad output enable (0 = high impedance) |

## Verification
On every cycle, the assertions check the flag set, hold and clear rules, including the case where an event and a read fall on the same edge. They also check the pulse counter's countdown and its cut on a read, that the pad never drives high while released, and that the pin is silent one edge after the supply or recall gate drops. The bench scenarios show the effects that span time: the exact pulse length, and that extra events neither restart nor stretch a pulse. They also show the end-to-end latency in level mode, both polarity and drive encodings at the pad, and that disabled sources raise flags but never the pin.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic pulse_mode;
    logic act_high;
  } irq_mode_t;
endpackage

// File: rtl/irq_flag_store.sv
module irq_flag_store #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt,
  input  logic             rd,
  output logic [N_SRC-1:0] flags
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= evt[i] | (flags[i] & ~rd);
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> flags[i]);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !rd) |=> flags[i]);
    assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (rst)
      (rd && !evt[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_pkg::*;
#(
  parameter int N_SRC = 3,
  localparam int CTL_W = N_SRC + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [N_SRC-1:0] en,
  output irq_mode_t        mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      mode <= '0;
    end else if (we) begin
      en   <= wdata[N_SRC-1:0];
      mode <= wdata[CTL_W-1:N_SRC];
    end
  end
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int PULSE_CYC = 40_000_000,
  localparam int CNT_W = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic pending,
  input  logic clr,
  output logic busy
);
  logic             pend_d;
  logic [CNT_W-1:0] cnt;
  logic             start;

  assign start = arm & pending & ~pend_d & (cnt == '0);
  assign busy  = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_d <= 1'b0;
      cnt    <= '0;
    end else begin
      pend_d <= pending;
      if (clr)        cnt <= '0;
      else if (start) cnt <= CNT_W'(PULSE_CYC);
      else if (busy)  cnt <= cnt - CNT_W'(1);
    end
  end

  assert_countdown_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !clr) |=> (cnt == $past(cnt) - CNT_W'(1)));
  assert_cut_on_read_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/irq_pin_driver.sv
module irq_pin_driver (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic act_high,
  output logic drv,
  output logic oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drv <= 1'b0;
      oe  <= 1'b0;
    end else if (act_high) begin
      drv <= active;
      oe  <= 1'b1;
    end else begin
      drv <= 1'b0;
      oe  <= active;
    end
  end

  assert_no_drive_when_released_R8: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !drv);
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC     = 3,
  parameter int PULSE_CYC = 40_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   evt_in,
  input  logic               flags_rd,
  input  logic               ctl_we,
  input  logic [N_SRC+1:0]   ctl_wdata,
  input  logic               supply_ok,
  input  logic               recall_done,
  output logic [N_SRC-1:0]   flags_q,
  output logic               pin_drv,
  output logic               pin_oe
);
  logic [N_SRC-1:0] en;
  irq_mode_t        mode;
  logic             power_ok;
  logic             pending;
  logic             busy;
  logic             active;

  irq_flag_store #(.N_SRC(N_SRC)) u_flags (
    .clk(clk), .rst(rst), .evt(evt_in), .rd(flags_rd), .flags(flags_q)
  );

  irq_ctl_reg #(.N_SRC(N_SRC)) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata), .en(en), .mode(mode)
  );

  assign power_ok = supply_ok & recall_done;
  assign pending  = (|(flags_q & en)) & power_ok;

  irq_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst(rst), .arm(mode.pulse_mode), .pending(pending),
    .clr(flags_rd), .busy(busy)
  );

  assign active = (mode.pulse_mode ? busy : pending) & power_ok;

  irq_pin_driver u_drv (
    .clk(clk), .rst(rst), .active(active), .act_high(mode.act_high),
    .drv(pin_drv), .oe(pin_oe)
  );

  assert_gate_power_R9: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok || !recall_done) |=> !pin_drv);
  assert_enable_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (!mode.pulse_mode && ((flags_q & en) == '0)) |=> !pin_drv);
endmodule

// File: tb/test_irq_pin_ctrl.sv
module test_irq_pin_ctrl;
  localparam int PW = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] evt_in = '0;
  logic       flags_rd = 1'b0;
  logic       ctl_we = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic       supply_ok = 1'b1;
  logic       recall_done = 1'b1;
  logic [2:0] flags_q;
  logic       pin_drv, pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_pin_ctrl #(.N_SRC(3), .PULSE_CYC(PW)) i_irq_pin_ctrl (
    .clk(clk), .rst(rst), .evt_in(evt_in), .flags_rd(flags_rd),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .supply_ok(supply_ok),
    .recall_done(recall_done), .flags_q(flags_q), .pin_drv(pin_drv), .pin_oe(pin_oe)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pad code {oe,drv}: 2'b11 high active, 2'b10 high idle or low active, 2'b00 released
  task automatic chk_pin(string tag, logic [1:0] exp);
    chk(tag, {30'd0, pin_oe, pin_drv}, {30'd0, exp});
  endtask

  task automatic wr_ctl(logic [2:0] en, logic pol, logic pls);
    ctl_wdata = {pls, pol, en};
    ctl_we = 1'b1;
    step();
    ctl_we = 1'b0;
  endtask

  task automatic do_rd();
    flags_rd = 1'b1;
    step();
    flags_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flags after reset", flags_q, 0);
    chk_pin("R1 pin released after reset", 2'b00);
  endtask

  task automatic t_flags();
    wr_ctl(3'b000, 1'b0, 1'b0);
    evt_in = 3'b111;
    step();
    evt_in = '0;
    chk("R2 all flags set", flags_q, 3'b111);
    repeat (3) step();
    chk("R2 flags sticky", flags_q, 3'b111);
    chk_pin("R4 disabled sources keep pin quiet", 2'b00);
    flags_rd = 1'b1;
    evt_in = 3'b010;
    step();
    flags_rd = 1'b0;
    evt_in = '0;
    chk("R3 same-edge event survives read", flags_q, 3'b010);
    do_rd();
    chk("R3 read clears flags", flags_q, 0);
  endtask

  task automatic t_level();
    wr_ctl(3'b001, 1'b0, 1'b0);
    step();
    evt_in = 3'b010;
    step();
    evt_in = '0;
    step();
    chk_pin("R4 alarm disabled no pin", 2'b00);
    chk("R4 alarm flag still set", flags_q, 3'b010);
    evt_in = 3'b001;
    step();
    evt_in = '0;
    chk_pin("R5 not yet active one edge after event", 2'b00);
    step();
    chk_pin("R5 R8 open-drain active low", 2'b10);
    repeat (3) step();
    chk_pin("R5 level holds", 2'b10);
    do_rd();
    chk("R3 flags cleared", flags_q, 0);
    step();
    chk_pin("R5 released after read", 2'b00);
    wr_ctl(3'b001, 1'b1, 1'b0);
    step();
    chk_pin("R8 push-pull idle low", 2'b10);
    evt_in = 3'b001;
    step();
    evt_in = '0;
    step();
    chk_pin("R8 push-pull active high", 2'b11);
    do_rd();
    step();
    chk_pin("R5 push-pull back idle", 2'b10);
  endtask

  task automatic t_pulse();
    do_rd();
    wr_ctl(3'b110, 1'b1, 1'b1);
    step();
    evt_in = 3'b100;
    step();
    evt_in = '0;
    chk_pin("R6 idle at event edge", 2'b10);
    step();
    chk_pin("R6 idle one edge later", 2'b10);
    for (int k = 1; k <= PW; k++) begin
      if (k == 3) evt_in = 3'b010;
      step();
      evt_in = '0;
      chk_pin("R6 pulse active", 2'b11);
    end
    step();
    chk_pin("R6 pulse ended after width", 2'b10);
    for (int k = 0; k < 4; k++) begin
      step();
      chk_pin("R6 no restart with flags left set", 2'b10);
    end
    do_rd();
  endtask

  task automatic t_cut();
    do_rd();
    step();
    evt_in = 3'b100;
    step();
    evt_in = '0;
    step();
    step();
    step();
    chk_pin("R7 pulse running", 2'b11);
    do_rd();
    step();
    chk_pin("R7 pulse cut by read", 2'b10);
    for (int k = 0; k < PW; k++) step();
    chk_pin("R7 stays idle after cut", 2'b10);
    chk("R7 flags cleared by cut", flags_q, 0);
  endtask

  task automatic t_gate();
    do_rd();
    wr_ctl(3'b111, 1'b1, 1'b0);
    step();
    supply_ok = 1'b0;
    evt_in = 3'b010;
    step();
    evt_in = '0;
    step();
    step();
    chk_pin("R9 backup power keeps pin idle", 2'b10);
    chk("R9 flag recorded on backup", flags_q, 3'b010);
    supply_ok = 1'b1;
    step();
    chk_pin("R9 active after supply returns", 2'b11);
    recall_done = 1'b0;
    step();
    chk_pin("R9 recall pending keeps pin idle", 2'b10);
    recall_done = 1'b1;
    step();
    chk_pin("R9 active after recall", 2'b11);
    do_rd();
    step();
    chk_pin("R5 idle after read", 2'b10);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_flags();
    t_level();
    t_pulse();
    t_cut();
    t_gate();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule